// File: doc/BRIEF.md
# Core Clock Divider and Peripheral Clock Gate

This unit sits beside a small 4-bit processor core and turns raw clock-enable pulses into the enables the core and its peripherals run from. The core programs it through one 4-bit control word on a simple register bus. Two source pulses arrive: one from an internal RC oscillator and one from an alternative source that is picked elsewhere. The word selects which of the two feeds the system clock divider. It sets the divide ratio to 2, 4, 8 or 16. It also decides whether the peripheral clock enable keeps running while the core sleeps.

Everything runs on one clock. Sources arrive as single-cycle enable pulses. The divider counts them and emits a single-cycle system enable, so no derived clock is ever built. A new ratio waits for the current divider period to finish, so no short period appears. A change of source restarts the count from zero. A peripheral clock taken from the 32 kHz crystal is never gated, whatever the sleep setting.

Top module: `clk_mgmt_unit`

## Requirements
- R1: After reset the control word reads 4'b1111: RC source, keep-peripheral set, speed code 11. The system enable then pulses once every 2 RC enables.
- R2: A write with address 4'hE loads the word. Bit 3 is keep-peripheral, bit 2 is source select (1 = RC, 0 = alternative) and bits 1:0 are the speed code. A read at 4'hE returns the word, and a read at any other address returns 0.
- R3: A write to any address other than 4'hE leaves the control word unchanged.
- R4: Speed code 00 gives one system pulse per 16 source enables, 01 per 8, 10 per 4 and 11 per 2. Each system pulse is one cycle wide and appears in the cycle after the source enable that completes the count.
- R5: Only the selected source's enables advance the divider. Pulses on the other source have no effect on the system enable.
- R6: A new speed code written in the middle of a divider period takes effect only after that period wraps. The period in progress completes at the old ratio.
- R7: A write that changes the source bit clears the divider count. The first system pulse then appears after a full divisor count of new-source enables. With the new source pulsing every cycle, that pulse is visible divisor+1 cycles after the write edge.
- R8: The peripheral enable follows the peripheral source enable one cycle later. It is suppressed only when sleep is asserted, keep-peripheral is 0 and the crystal flag is 0.
- R9: When the crystal flag is 1, the peripheral enable is never suppressed, whatever the sleep input and the keep-peripheral bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register bus address |
| busWrEn | input | 1 | Register bus write strobe |
| busWrData | input | 4 | Register bus write data |
| busRdData | output | 4 | Register bus read data (combinational) |
| rcTick | input | 1 | Enable pulse from the internal RC oscillator |
| altTick | input | 1 | Enable pulse from the alternative source |
| subTick | input | 1 | Peripheral source enable pulse |
| sleepMode | input | 1 | Core is in sleep |
| periphFromXtal | input | 1 | Peripheral clock is taken from the 32 kHz crystal |
| sysTick | output | 1 | Divided system clock enable |
| periphTick | output | 1 | Gated peripheral clock enable |

## Verification
Read data is combinational, so it is sampled shortly after the address settles. A register write lands at the write edge, and the peripheral enable is due exactly one edge after its inputs change, so the gating sweep waits two edges before sampling. System pulse spacing is measured from time stamps that a monitor records one nanosecond after each rising edge. Only gaps between pulses that lie entirely after a configuration change are compared against the ratio. For the source-switch case the bench counts edges from the write edge and expects the pulse at divisor plus one, which accounts for the one-cycle registered strobe.

// File: rtl/clkmgmt_pkg.sv
package clkmgmt_pkg;
  localparam int SPEED_W  = 2;
  localparam int REG_W    = 4;
  localparam int KEEP_BIT = 3;
  localparam int SRC_BIT  = 2;
  localparam int MAXCODE  = (1 << SPEED_W) - 1;
  // largest divisor is 2 << MAXCODE, so the count needs 1 << SPEED_W bits
  localparam int CNT_W    = 1 << SPEED_W;

  typedef struct packed {
    logic               srcChange;
    logic               reqSrc;
    logic [SPEED_W-1:0] reqSpeed;
  } ctrlStrobe_t;

  function automatic logic [CNT_W-1:0] lastCount(input logic [SPEED_W-1:0] code);
    logic [CNT_W:0] span;
    span = (CNT_W+1)'(2) << (MAXCODE - int'(code));
    return CNT_W'(span - 1'b1);
  endfunction
endpackage

// File: rtl/clkmgmt_ctrl.sv
module clkmgmt_ctrl
  import clkmgmt_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  input  logic              subTick,
  input  logic              sleepMode,
  input  logic              periphFromXtal,
  output logic              periphTick,
  output logic [REG_W-1:0]  ctrlWord,
  output ctrlStrobe_t       strobe
);
  logic hit;
  logic srcFlip;
  logic periphAllow;

  assign hit     = (busAddr == CTRL_ADDR);
  assign srcFlip = busWrEn && hit && (busWrData[SRC_BIT] != ctrlWord[SRC_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrlWord         <= '1;
      strobe.srcChange <= 1'b0;
    end else begin
      strobe.srcChange <= srcFlip;
      if (busWrEn && hit) ctrlWord <= busWrData;
    end
  end

  assign strobe.reqSrc   = ctrlWord[SRC_BIT];
  assign strobe.reqSpeed = ctrlWord[SPEED_W-1:0];
  assign busRdData       = hit ? ctrlWord : '0;

  // a crystal-fed peripheral clock can never be stopped
  assign periphAllow = !sleepMode || ctrlWord[KEEP_BIT] || periphFromXtal;

  always_ff @(posedge clk) begin
    if (!rst_n) periphTick <= 1'b0;
    else        periphTick <= subTick && periphAllow;
  end
endmodule

// File: rtl/clkmgmt_datapath.sv
module clkmgmt_datapath
  import clkmgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ctrlStrobe_t strobe,
  input  logic        rcTick,
  input  logic        altTick,
  output logic        sysTick
);
  logic               actSrc;
  logic [SPEED_W-1:0] actSpeed;
  logic [SPEED_W-1:0] effSpeed;
  logic [CNT_W-1:0]   cnt;
  logic               srcTick;
  logic               atEnd;

  assign srcTick  = actSrc ? rcTick : altTick;
  // at a period boundary the requested speed is adopted at once
  assign effSpeed = (cnt == '0) ? strobe.reqSpeed : actSpeed;
  assign atEnd    = (cnt == lastCount(effSpeed));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actSrc   <= 1'b1;
      actSpeed <= '1;
      cnt      <= '0;
      sysTick  <= 1'b0;
    end else if (strobe.srcChange) begin
      actSrc   <= strobe.reqSrc;
      actSpeed <= strobe.reqSpeed;
      cnt      <= '0;
      sysTick  <= 1'b0;
    end else begin
      actSpeed <= effSpeed;
      sysTick  <= srcTick && atEnd;
      if (srcTick) cnt <= atEnd ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clk_mgmt_unit.sv
module clk_mgmt_unit
  import clkmgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       busAddr,
  input  logic             busWrEn,
  input  logic [REG_W-1:0] busWrData,
  output logic [REG_W-1:0] busRdData,
  input  logic             rcTick,
  input  logic             altTick,
  input  logic             subTick,
  input  logic             sleepMode,
  input  logic             periphFromXtal,
  output logic             sysTick,
  output logic             periphTick
);
  ctrlStrobe_t      strobe;
  logic [REG_W-1:0] ctrlWord;

  clkmgmt_ctrl #(.ADDR_W(4), .CTRL_ADDR(4'hE)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .subTick(subTick),
    .sleepMode(sleepMode), .periphFromXtal(periphFromXtal),
    .periphTick(periphTick), .ctrlWord(ctrlWord), .strobe(strobe)
  );

  clkmgmt_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .rcTick(rcTick), .altTick(altTick), .sysTick(sysTick)
  );
endmodule

// File: rtl/clkmgmt_checker.sv
module clkmgmt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] busAddr,
  input logic       busWrEn,
  input logic       rcTick,
  input logic       altTick,
  input logic       subTick,
  input logic       sleepMode,
  input logic       periphFromXtal,
  input logic       sysTick,
  input logic       periphTick,
  input logic [3:0] ctrlWord
);
  AST_SYS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sysTick |=> !sysTick); // R4
  AST_SYS_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    sysTick |-> $past(rcTick || altTick)); // R5
  AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busWrEn && busAddr != 4'hE) |=> $stable(ctrlWord)); // R3
  AST_PERIPH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (sleepMode && !ctrlWord[3] && !periphFromXtal) |=> !periphTick); // R8
  AST_XTAL_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (subTick && periphFromXtal) |=> periphTick); // R9
endmodule

bind clk_mgmt_unit clkmgmt_checker i_checker (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
  .rcTick(rcTick), .altTick(altTick), .subTick(subTick),
  .sleepMode(sleepMode), .periphFromXtal(periphFromXtal),
  .sysTick(sysTick), .periphTick(periphTick), .ctrlWord(ctrlWord)
);

// File: tb/test_clk_mgmt_unit.sv
module test_clk_mgmt_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic busWrEn = 1'b0;
  logic [3:0] busWrData = 4'h0;
  logic [3:0] busRdData;
  logic rcTick = 1'b0, altTick = 1'b0, subTick = 1'b0;
  logic sleepMode = 1'b0, periphFromXtal = 1'b0;
  logic sysTick, periphTick;

  int total = 0, bad = 0, cyc = 0;
  int rcMode = 1;   // 0 off, 1 every cycle, 2 every other cycle
  int altMode = 0;
  int pulseCount = 0, lastPulse = 0, prevPulse = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_mgmt_unit i_clk_mgmt_unit (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .rcTick(rcTick),
    .altTick(altTick), .subTick(subTick), .sleepMode(sleepMode),
    .periphFromXtal(periphFromXtal), .sysTick(sysTick), .periphTick(periphTick)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    if (sysTick) begin
      prevPulse = lastPulse;
      lastPulse = cyc;
      pulseCount++;
    end
    rcTick  <= (rcMode == 1) ? 1'b1 : (rcMode == 2) ? ~rcTick : 1'b0;
    altTick <= (altMode == 1) ? 1'b1 : (altMode == 2) ? ~altTick : 1'b0;
    if (cyc > 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [3:0] d);
    @(negedge clk);
    busAddr = a; #1;
    d = busRdData;
  endtask

  task automatic waitPulses(input int k);
    int target;
    target = pulseCount + k;
    while (pulseCount < target) @(posedge clk);
    #2;
  endtask

  task automatic pulsesIn(input int n, output int c);
    int start;
    start = pulseCount;
    repeat (n) @(posedge clk);
    #2;
    c = pulseCount - start;
  endtask

  initial begin
    logic [3:0] rd;
    int gap, c, n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset value and divide-by-2 from RC
    regRead(4'hE, rd);
    check(rd == 4'hF, "R1 reset word", rd, 15);
    waitPulses(3);
    gap = lastPulse - prevPulse;
    check(gap == 2, "R1 reset ratio", gap, 2);

    // R4: ratio sweep, RC every cycle and every other cycle
    for (int m = 1; m <= 2; m++) begin
      rcMode = m;
      for (int s = 0; s < 4; s++) begin
        regWrite(4'hE, {2'b11, s[1:0]});
        waitPulses(3);
        gap = lastPulse - prevPulse;
        check(gap == m * (2 << (3 - s)), "R4 divider gap", gap, m * (2 << (3 - s)));
      end
    end
    rcMode = 1;

    // R2: readback and other-address read
    regWrite(4'hE, 4'h9);
    regRead(4'hE, rd);
    check(rd == 4'h9, "R2 readback", rd, 9);
    regRead(4'h5, rd);
    check(rd == 4'h0, "R2 foreign read", rd, 0);

    // R3: foreign writes ignored
    for (int a = 0; a < 16; a++) begin
      if (a != 14) regWrite(a[3:0], 4'h6);
    end
    regRead(4'hE, rd);
    check(rd == 4'h9, "R3 foreign write", rd, 9);

    // R5: alternative selected and idle, RC running -> no pulses
    pulsesIn(60, c);
    check(c == 0, "R5 rc ignored", c, 0);
    altMode = 1;
    waitPulses(3);
    gap = lastPulse - prevPulse;
    check(gap == 8, "R5 alt counted", gap, 8);
    rcMode = 0;
    regWrite(4'hE, 4'hF);
    pulsesIn(60, c);
    check(c == 0, "R5 alt ignored", c, 0);

    // R7: source switch restarts count (speed 10, divisor 4)
    rcMode = 1;
    regWrite(4'hE, 4'hE);
    waitPulses(3);
    regWrite(4'hE, 4'hA);
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!sysTick && n < 100);
    check(n == 5, "R7 first pulse after switch", n, 5);

    // R6: speed change mid-period completes old period
    altMode = 0;
    regWrite(4'hE, 4'hC);
    waitPulses(3);
    repeat (5) @(posedge clk);
    regWrite(4'hE, 4'hF);
    waitPulses(1);
    gap = lastPulse - prevPulse;
    check(gap == 16, "R6 old period kept", gap, 16);
    waitPulses(1);
    gap = lastPulse - prevPulse;
    check(gap == 2, "R6 new period", gap, 2);

    // R8/R9: peripheral gating sweep
    subTick = 1'b1;
    for (int k = 0; k < 2; k++) begin
      regWrite(4'hE, {k[0], 3'b111});
      for (int sl = 0; sl < 2; sl++) begin
        for (int x = 0; x < 2; x++) begin
          int exp;
          @(negedge clk);
          sleepMode = sl[0]; periphFromXtal = x[0];
          @(posedge clk); @(posedge clk); #1;
          exp = (sl == 1 && k == 0 && x == 0) ? 0 : 1;
          if (x == 1) check(periphTick == exp[0], "R9 xtal never stops", periphTick, exp);
          else        check(periphTick == exp[0], "R8 sleep gating", periphTick, exp);
        end
      end
    end
    @(negedge clk);
    subTick = 1'b0; sleepMode = 1'b0; periphFromXtal = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(periphTick == 1'b0, "R8 no source pulse", periphTick, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule